// File: doc/BRIEF.md
# Coherent Write-Back Cache Controller with Private Line Tracking

This block is the cache-side controller for one processor in a system where several caches share a main memory. Memory keeps a presence directory, so it sends invalidation or write-back orders only to caches that hold a copy. The controller keeps a small 2-way set-associative tag store. Each line carries a valid bit, a private bit (meaning this cache holds the only copy), one block word of data, and one least-recently-used bit per set. It works in write-back mode on whole blocks.

On the processor side, a held request (load or store) is acknowledged with `procAck` in the cycle where the controller completes it. Towards memory it issues block reads (standard or exclusive), exclusivity requests, and evictions. It holds each command on `memCmd*` until memory pulses `memDone`. Memory-initiated write-back (update) and invalidate (purge) orders arrive on the `snp*` inputs. They are answered one cycle later on a separate reply channel that never waits on memory, so they are served even while a processor request is stalled.

Top module: `coh_cache`

## Requirements
- R1: After reset every line is invalid, `procAck`, `memCmdValid` and `snpRespValid` are low, and the first access to any address misses.
- R2: A lookup hits only when the tag matches and the line is valid. A load hit, or a store hit to a private line, raises `procAck` in the first cycle of the request with no memory command. `procRData` carries the line data in that cycle.
- R3: A load miss issues a standard read (`memCmdOp` 0) for the requested block address. The block returned with `memDone` is installed valid and not private.
- R4: A store miss issues an exclusive read (op 1). A store hit to a non-private line first issues an exclusivity request (op 2). Either way the line then becomes private and takes the store data, so a further store to it issues no command.
- R5: When a miss replaces a valid line, the victim is sent out before the read. A private victim goes as write-and-eject (op 5) with its data, and a non-private victim as eject (op 4). Replacing an invalid line sends nothing.
- R6: The victim is an invalid way if the set has one, way 0 before way 1. Otherwise it is the least recently used way. Hits and installs both count as uses.
- R7: An update order (`snpOp` 0) for a valid private line replies write (`snpRespOp` 1) with the line data and clears the private bit. Any other update replies none (0).
- R8: A purge order (`snpOp` 1) for a valid line replies write-and-eject (3) with data if the line is private, and eject (2) otherwise, and invalidates the line. A purge that misses replies none (0).
- R9: Every memory order is answered on the cycle after it is presented, in every controller state, including while a memory command awaits `memDone`. `snpRespAddr` echoes the order's address.
- R10: When an order and a processor lookup fall in the same cycle, the order is served first and `procAck` stays low that cycle.
- R11: If a purge removes the line while its exclusivity request is outstanding, the store is retried as a store miss with an exclusive read once `memDone` arrives.
- R12: `memCmdValid`, `memCmdOp`, `memCmdAddr` and `memCmdData` hold steady until the cycle in which `memDone` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procReq | input | 1 | Processor request, held until `procAck` |
| procStore | input | 1 | 1 for store, 0 for load |
| procAddr | input | ADDR_W | Block address of the request |
| procWData | input | DATA_W | Store data |
| procAck | output | 1 | Request completes this cycle |
| procRData | output | DATA_W | Load data, valid with `procAck` |
| memCmdValid | output | 1 | Memory command pending |
| memCmdOp | output | 3 | 0 read, 1 exclusive read, 2 exclusivity, 4 eject, 5 write-and-eject |
| memCmdAddr | output | ADDR_W | Command block address |
| memCmdData | output | DATA_W | Write-back data for op 5 |
| memDone | input | 1 | One-cycle completion of the pending command |
| memRData | input | DATA_W | Block data returned with `memDone` on a read |
| snpValid | input | 1 | Memory order present this cycle |
| snpOp | input | 1 | 0 update, 1 purge |
| snpAddr | input | ADDR_W | Order block address |
| snpRespValid | output | 1 | Reply to the previous cycle's order |
| snpRespOp | output | 2 | 0 none, 1 write, 2 eject, 3 write-and-eject |
| snpRespAddr | output | ADDR_W | Address of the order answered |
| snpRespData | output | DATA_W | Line data for replies 1 and 3 |

## Verification
A memory order can land in the same cycle as a processor lookup or a line install. It can also arrive while a read or exclusivity request is waiting for `memDone`. The bench raises a purge together with a load hit to the same line and judges the order from the eject reply, a low `procAck` in that cycle, and a fresh read afterwards. It also stretches memory latency so that purges land during a pending read and during a pending exclusivity request, then checks that the reply arrives before `memDone` and that the interrupted store is retried as an exclusive read.

// File: rtl/coh_cache_pkg.sv
package coh_cache_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_READX = 3'd1,
    CMD_EXCL  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_EJECT = 3'd4,
    CMD_WEJ   = 3'd5
  } memOp_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_WRITE = 2'd1,
    RSP_EJECT = 2'd2,
    RSP_WEJ   = 2'd3
  } snpRsp_e;

  localparam logic SNP_UPDATE = 1'b0;
  localparam logic SNP_PURGE  = 1'b1;

  // control -> datapath strobes
  typedef struct packed {
    logic touch;
    logic storeWr;
    logic latchVictim;
    logic invVictim;
    logic install;
    logic installPriv;
    logic setPriv;
  } strobe_t;

  // datapath -> control lookup status
  typedef struct packed {
    logic hit;
    logic hitPriv;
    logic vicValid;
    logic vicPriv;
  } dpStat_t;

endpackage

// File: rtl/coh_cache_dp.sv
module coh_cache_dp
  import coh_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procWData,
  input  logic [DATA_W-1:0] memRData,
  input  strobe_t           strb,
  input  logic              snpValid,
  input  logic              snpOp,
  input  logic [ADDR_W-1:0] snpAddr,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] vicAddr,
  output logic [DATA_W-1:0] vicData,
  output logic [DATA_W-1:0] procRData,
  output logic              snpRespValid,
  output logic [1:0]        snpRespOp,
  output logic [ADDR_W-1:0] snpRespAddr,
  output logic [DATA_W-1:0] snpRespData
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]   validQ [WAYS];
  logic [SETS-1:0]   privQ  [WAYS];
  logic [SETS-1:0]   lruQ;
  logic [TAG_W-1:0]  tagQ   [WAYS][SETS];
  logic [DATA_W-1:0] dataQ  [WAYS][SETS];
  logic              vicWayQ;

  logic [IDX_W-1:0] idx, sIdx;
  logic [TAG_W-1:0] tag, sTag;
  logic [WAYS-1:0]  hitW, sHitW;
  logic             hitWay, sWay, sHit, sPriv, vsel;
  logic [1:0]       rspOp;

  assign idx  = procAddr[IDX_W-1:0];
  assign tag  = procAddr[ADDR_W-1:IDX_W];
  assign sIdx = snpAddr[IDX_W-1:0];
  assign sTag = snpAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitW[w]  = validQ[w][idx]  && (tagQ[w][idx]  == tag);
    assign sHitW[w] = validQ[w][sIdx] && (tagQ[w][sIdx] == sTag);
  end

  assign hitWay = hitW[1];
  assign sWay   = sHitW[1];
  assign sHit   = |sHitW;
  assign sPriv  = privQ[sWay][sIdx];

  // invalid way first (way 0 before way 1), else the LRU way
  always_comb begin
    if (!validQ[0][idx])      vsel = 1'b0;
    else if (!validQ[1][idx]) vsel = 1'b1;
    else                      vsel = lruQ[idx];
  end

  assign stat.hit      = |hitW;
  assign stat.hitPriv  = privQ[hitWay][idx];
  assign stat.vicValid = validQ[vsel][idx];
  assign stat.vicPriv  = privQ[vsel][idx];
  assign vicAddr       = {tagQ[vsel][idx], idx};
  assign vicData       = dataQ[vsel][idx];
  assign procRData     = dataQ[hitWay][idx];

  always_comb begin
    rspOp = RSP_NONE;
    if (snpValid && sHit) begin
      if (snpOp == SNP_PURGE) rspOp = sPriv ? RSP_WEJ : RSP_EJECT;
      else if (sPriv)         rspOp = RSP_WRITE;
    end
  end

  // line state; memory orders are applied last so they win any overlap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        validQ[w] <= '0;
        privQ[w]  <= '0;
      end
      lruQ         <= '0;
      vicWayQ      <= 1'b0;
      snpRespValid <= 1'b0;
      snpRespOp    <= RSP_NONE;
      snpRespAddr  <= '0;
      snpRespData  <= '0;
    end else begin
      if (strb.touch)       lruQ[idx] <= ~hitWay;
      if (strb.latchVictim) vicWayQ   <= vsel;
      if (strb.invVictim) begin
        validQ[vsel][idx] <= 1'b0;
        privQ[vsel][idx]  <= 1'b0;
      end
      if (strb.install) begin
        validQ[vicWayQ][idx] <= 1'b1;
        privQ[vicWayQ][idx]  <= strb.installPriv;
        lruQ[idx]            <= ~vicWayQ;
      end
      if (strb.setPriv && stat.hit) privQ[hitWay][idx] <= 1'b1;
      if (snpValid && sHit) begin
        privQ[sWay][sIdx] <= 1'b0;
        if (snpOp == SNP_PURGE) validQ[sWay][sIdx] <= 1'b0;
      end
      snpRespValid <= snpValid;
      snpRespOp    <= rspOp;
      snpRespAddr  <= snpAddr;
      snpRespData  <= dataQ[sWay][sIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeWr) dataQ[hitWay][idx] <= procWData;
    if (strb.install) begin
      tagQ[vicWayQ][idx]  <= tag;
      dataQ[vicWayQ][idx] <= memRData;
    end
  end

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procReq,
  input  logic              procStore,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic              snpValid,
  input  logic              memDone,
  input  dpStat_t           stat,
  input  logic [ADDR_W-1:0] vicAddr,
  input  logic [DATA_W-1:0] vicData,
  output strobe_t           strb,
  output logic              procAck,
  output logic              memCmdValid,
  output logic [2:0]        memCmdOp,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [DATA_W-1:0] memCmdData
);
  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_READ, S_EXCL} state_e;

  state_e            stateQ, stateD;
  logic              issue;
  memOp_e            issOp;
  logic [ADDR_W-1:0] issAddr;
  logic [DATA_W-1:0] issData;

  always_comb begin
    stateD  = stateQ;
    strb    = '0;
    procAck = 1'b0;
    issue   = 1'b0;
    issOp   = CMD_READ;
    issAddr = procAddr;
    issData = '0;
    unique case (stateQ)
      S_LOOK: if (procReq && !snpValid) begin
        if (stat.hit && (!procStore || stat.hitPriv)) begin
          procAck      = 1'b1;
          strb.touch   = 1'b1;
          strb.storeWr = procStore;
        end else if (stat.hit) begin
          issue  = 1'b1;
          issOp  = CMD_EXCL;
          stateD = S_EXCL;
        end else begin
          strb.latchVictim = 1'b1;
          issue            = 1'b1;
          if (stat.vicValid) begin
            strb.invVictim = 1'b1;
            issOp   = stat.vicPriv ? CMD_WEJ : CMD_EJECT;
            issAddr = vicAddr;
            issData = vicData;
            stateD  = S_EVICT;
          end else begin
            issOp  = procStore ? CMD_READX : CMD_READ;
            stateD = S_READ;
          end
        end
      end
      S_EVICT: if (memDone) begin
        issue  = 1'b1;
        issOp  = procStore ? CMD_READX : CMD_READ;
        stateD = S_READ;
      end
      S_READ: if (memDone) begin
        strb.install     = 1'b1;
        strb.installPriv = procStore;
        stateD           = S_LOOK;
      end
      S_EXCL: if (memDone) begin
        strb.setPriv = 1'b1;
        stateD       = S_LOOK;
      end
      default: stateD = S_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= S_LOOK;
      memCmdValid <= 1'b0;
      memCmdOp    <= CMD_READ;
      memCmdAddr  <= '0;
      memCmdData  <= '0;
    end else begin
      stateQ <= stateD;
      if (issue) begin
        memCmdValid <= 1'b1;
        memCmdOp    <= issOp;
        memCmdAddr  <= issAddr;
        memCmdData  <= issData;
      end else if (memDone) begin
        memCmdValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procReq,
  input  logic              procStore,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procWData,
  output logic              procAck,
  output logic [DATA_W-1:0] procRData,
  output logic              memCmdValid,
  output logic [2:0]        memCmdOp,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic [DATA_W-1:0] memCmdData,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRData,
  input  logic              snpValid,
  input  logic              snpOp,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpRespValid,
  output logic [1:0]        snpRespOp,
  output logic [ADDR_W-1:0] snpRespAddr,
  output logic [DATA_W-1:0] snpRespData
);
  strobe_t           strb;
  dpStat_t           stat;
  logic [ADDR_W-1:0] vicAddr;
  logic [DATA_W-1:0] vicData;

  coh_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .procReq(procReq), .procStore(procStore),
    .procAddr(procAddr), .snpValid(snpValid), .memDone(memDone),
    .stat(stat), .vicAddr(vicAddr), .vicData(vicData), .strb(strb),
    .procAck(procAck), .memCmdValid(memCmdValid), .memCmdOp(memCmdOp),
    .memCmdAddr(memCmdAddr), .memCmdData(memCmdData)
  );

  coh_cache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_dp (
    .clk(clk), .rstN(rstN), .procAddr(procAddr), .procWData(procWData),
    .memRData(memRData), .strb(strb), .snpValid(snpValid), .snpOp(snpOp),
    .snpAddr(snpAddr), .stat(stat), .vicAddr(vicAddr), .vicData(vicData),
    .procRData(procRData), .snpRespValid(snpRespValid), .snpRespOp(snpRespOp),
    .snpRespAddr(snpRespAddr), .snpRespData(snpRespData)
  );

endmodule

// File: rtl/coh_cache_chk.sv
module coh_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              procReq,
  input logic              procAck,
  input logic              snpValid,
  input logic              snpRespValid,
  input logic              memCmdValid,
  input logic [2:0]        memCmdOp,
  input logic [ADDR_W-1:0] memCmdAddr,
  input logic [DATA_W-1:0] memCmdData,
  input logic              memDone
);
  // R12: a pending command stays put until memory completes it
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memCmdValid && !memDone) |=> (memCmdValid && $stable(memCmdOp) &&
                                   $stable(memCmdAddr) && $stable(memCmdData)));

  // R9: every memory order is answered on the next cycle
  p_snoop_reply_r9: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |=> snpRespValid);

  // R9: no reply without an order
  p_reply_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    snpRespValid |-> $past(snpValid));

  // R10: an order in the cycle blocks processor completion
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !procAck);

  // R2: completion only for a live request and with no command outstanding
  p_ack_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    procAck |-> (procReq && !memCmdValid));

endmodule

bind coh_cache coh_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .procReq(procReq), .procAck(procAck),
  .snpValid(snpValid), .snpRespValid(snpRespValid), .memCmdValid(memCmdValid),
  .memCmdOp(memCmdOp), .memCmdAddr(memCmdAddr), .memCmdData(memCmdData),
  .memDone(memDone)
);

// File: tb/coh_cache_bench.sv
module coh_cache_bench;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procReq = 1'b0, procStore = 1'b0;
  logic [AW-1:0] procAddr = '0;
  logic [DW-1:0] procWData = '0;
  logic          procAck;
  logic [DW-1:0] procRData;
  logic          memCmdValid;
  logic [2:0]    memCmdOp;
  logic [AW-1:0] memCmdAddr;
  logic [DW-1:0] memCmdData;
  logic          memDone = 1'b0;
  logic [DW-1:0] memRData = '0;
  logic          snpValid = 1'b0, snpOp = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpRespValid;
  logic [1:0]    snpRespOp;
  logic [AW-1:0] snpRespAddr;
  logic [DW-1:0] snpRespData;

  always #10 clk = ~clk;  // 50 MHz

  coh_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u_coh_cache (.*);

  typedef struct {
    int    op;
    int    addr;
    int    data;
    bit    chk;
    string tag;
  } exp_t;

  exp_t          cmdQ[$];
  exp_t          snpQ[$];
  logic [DW-1:0] mem [256];
  int            checks = 0, errors = 0;
  int            memLat = 1;
  bit            busy = 0;
  int            cnt = 0;
  int            curOp, curAddr, curData;
  int            cycles = 0;

  function automatic logic [DW-1:0] initVal(input int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expCmd(input int op, input int a, input int d, input bit chk, input string tag);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.chk = chk; e.tag = tag;
    cmdQ.push_back(e);
  endtask

  task automatic expSnp(input int op, input int a, input int d, input bit chk, input string tag);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.chk = chk; e.tag = tag;
    snpQ.push_back(e);
  endtask

  // memory model and command monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memDone = 1'b0;
      busy    = 0;
    end else begin
      if (memDone) begin
        memDone = 1'b0;
        busy    = 0;
      end
      if (!busy && memCmdValid) begin
        exp_t e;
        busy    = 1;
        cnt     = memLat;
        curOp   = int'(memCmdOp);
        curAddr = int'(memCmdAddr);
        curData = int'(memCmdData);
        if (cmdQ.size() == 0) begin
          check(0, "R12", "unexpected command op", curOp, -1);
        end else begin
          e = cmdQ.pop_front();
          check(curOp == e.op, e.tag, "command op", curOp, e.op);
          check(curAddr == e.addr, e.tag, "command addr", curAddr, e.addr);
          if (e.chk) check(curData == e.data, e.tag, "command data", curData, e.data);
        end
      end else if (busy) begin
        if (cnt > 0) cnt--;
        else begin
          if (curOp == 5 || curOp == 3) mem[curAddr] = DW'(curData);
          if (curOp <= 1) memRData = mem[curAddr];
          memDone = 1'b1;
        end
      end
    end
  end

  // reply monitor
  always @(negedge clk) begin
    if (rstN && snpRespValid) begin
      exp_t e;
      if (snpQ.size() == 0) begin
        check(0, "R9", "unexpected reply op", int'(snpRespOp), -1);
      end else begin
        e = snpQ.pop_front();
        check(int'(snpRespOp) == e.op, e.tag, "reply op", int'(snpRespOp), e.op);
        check(int'(snpRespAddr) == e.addr, e.tag, "reply addr", int'(snpRespAddr), e.addr);
        if (e.chk) check(int'(snpRespData) == e.data, e.tag, "reply data", int'(snpRespData), e.data);
      end
      if (snpRespOp == 2'd1 || snpRespOp == 2'd3) mem[snpRespAddr] = snpRespData;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic access(input bit st, input int a, input int d, input bit expHit,
                        input bit chkData, input int expData, input string tag);
    int waited = 0;
    @(posedge clk); #1;
    procReq = 1'b1; procStore = st; procAddr = AW'(a); procWData = DW'(d);
    forever begin
      @(negedge clk);
      waited++;
      if (procAck) break;
    end
    if (!st && chkData) check(int'(procRData) == expData, tag, "load data", int'(procRData), expData);
    if (expHit) check(waited == 1, tag, "hit latency", waited, 1);
    @(posedge clk); #1;
    procReq = 1'b0;
    check(cmdQ.size() == 0, tag, "missing commands", cmdQ.size(), 0);
  endtask

  task automatic snoop(input bit op, input int a, input string tag);
    @(posedge clk); #1;
    snpValid = 1'b1; snpOp = op; snpAddr = AW'(a);
    @(posedge clk); #1;
    snpValid = 1'b0;
    @(negedge clk); #1;
    check(snpQ.size() == 0, tag, "missing reply", snpQ.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = initVal(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(procAck == 1'b0, "R1", "ack in reset", int'(procAck), 0);
    check(memCmdValid == 1'b0, "R1", "command in reset", int'(memCmdValid), 0);
    check(snpRespValid == 1'b0, "R1", "reply in reset", int'(snpRespValid), 0);
    rstN = 1'b1;

    // R1/R3: cold load misses with a standard read
    expCmd(0, 'h10, 0, 0, "R3");
    access(0, 'h10, 0, 0, 1, initVal('h10), "R3");
    // R2: load hit, one cycle
    access(0, 'h10, 0, 1, 1, initVal('h10), "R2");
    // R4: store to a shared line needs exclusivity, then private stores are silent
    expCmd(2, 'h10, 0, 0, "R4");
    access(1, 'h10, 'hA1A1, 0, 0, 0, "R4");
    access(1, 'h10, 'hB2B2, 1, 0, 0, "R4");
    access(0, 'h10, 0, 1, 1, 'hB2B2, "R2");
    // R6: invalid way used first, no eviction
    expCmd(1, 'h20, 0, 0, "R6");
    access(1, 'h20, 'hC3C3, 0, 0, 0, "R6");
    access(0, 'h10, 0, 1, 1, 'hB2B2, "R6");
    // R5/R6: LRU victim 0x20 is private -> write-and-eject with data
    expCmd(5, 'h20, 'hC3C3, 1, "R5");
    expCmd(0, 'h30, 0, 0, "R6");
    access(0, 'h30, 0, 0, 1, initVal('h30), "R6");
    expCmd(5, 'h10, 'hB2B2, 1, "R5");
    expCmd(0, 'h20, 0, 0, "R5");
    access(0, 'h20, 0, 0, 1, 'hC3C3, "R5");
    // R5: shared victim -> eject
    expCmd(4, 'h30, 0, 0, "R5");
    expCmd(0, 'h40, 0, 0, "R5");
    access(0, 'h40, 0, 0, 1, initVal('h40), "R5");

    // R7: update orders
    expCmd(0, 'h11, 0, 0, "R7");
    access(0, 'h11, 0, 0, 1, initVal('h11), "R7");
    expCmd(2, 'h11, 0, 0, "R7");
    access(1, 'h11, 'hD4D4, 0, 0, 0, "R7");
    expSnp(1, 'h11, 'hD4D4, 1, "R7");
    snoop(1'b0, 'h11, "R7");
    expCmd(2, 'h11, 0, 0, "R7");
    access(1, 'h11, 'hE5E5, 0, 0, 0, "R7");
    expSnp(1, 'h11, 'hE5E5, 1, "R7");
    snoop(1'b0, 'h11, "R7");
    expSnp(0, 'h11, 0, 0, "R7");
    snoop(1'b0, 'h11, "R7");

    // R8: purge orders
    expSnp(2, 'h20, 0, 0, "R8");
    snoop(1'b1, 'h20, "R8");
    expCmd(0, 'h20, 0, 0, "R8");
    access(0, 'h20, 0, 0, 1, 'hC3C3, "R8");
    expCmd(2, 'h11, 0, 0, "R8");
    access(1, 'h11, 'hF6F6, 0, 0, 0, "R8");
    expSnp(3, 'h11, 'hF6F6, 1, "R8");
    snoop(1'b1, 'h11, "R8");
    expCmd(0, 'h11, 0, 0, "R8");
    access(0, 'h11, 0, 0, 1, 'hF6F6, "R8");
    expSnp(0, 'h55, 0, 0, "R8");
    snoop(1'b1, 'h55, "R8");

    // R9: order served while a read is stalled
    expCmd(1, 'h12, 0, 0, "R9");
    access(1, 'h12, 'h7A7A, 0, 0, 0, "R9");
    memLat = 10;
    expCmd(0, 'h13, 0, 0, "R9");
    expSnp(3, 'h12, 'h7A7A, 1, "R9");
    fork
      access(0, 'h13, 0, 0, 1, initVal('h13), "R9");
      begin
        repeat (3) @(posedge clk);
        snoop(1'b1, 'h12, "R9");
        check(memCmdValid && !memDone, "R9", "reply before done", int'(memCmdValid), 1);
        check(memCmdOp == 3'd0 && memCmdAddr == AW'('h13), "R12", "held command addr",
              int'(memCmdAddr), 'h13);
      end
    join
    memLat = 1;

    // R10: order and lookup in the same cycle on the same line
    expSnp(2, 'h40, 0, 0, "R10");
    expCmd(0, 'h40, 0, 0, "R10");
    @(posedge clk); #1;
    procReq = 1'b1; procStore = 1'b0; procAddr = AW'('h40);
    snpValid = 1'b1; snpOp = 1'b1; snpAddr = AW'('h40);
    @(negedge clk);
    check(procAck == 1'b0, "R10", "ack with order", int'(procAck), 0);
    @(posedge clk); #1;
    snpValid = 1'b0;
    forever begin
      @(negedge clk);
      if (procAck) break;
    end
    check(int'(procRData) == int'(initVal('h40)), "R10", "load data", int'(procRData), int'(initVal('h40)));
    @(posedge clk); #1;
    procReq = 1'b0;
    check(cmdQ.size() == 0 && snpQ.size() == 0, "R10", "queues drained", cmdQ.size() + snpQ.size(), 0);

    // R11: purge during a pending exclusivity request
    expCmd(0, 'h22, 0, 0, "R11");
    access(0, 'h22, 0, 0, 1, initVal('h22), "R11");
    memLat = 10;
    expCmd(2, 'h22, 0, 0, "R11");
    expCmd(1, 'h22, 0, 0, "R11");
    expSnp(2, 'h22, 0, 0, "R11");
    fork
      access(1, 'h22, 'h8B8B, 0, 0, 0, "R11");
      begin
        repeat (3) @(posedge clk);
        snoop(1'b1, 'h22, "R11");
      end
    join
    memLat = 1;
    access(0, 'h22, 0, 1, 1, 'h8B8B, "R11");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule